// File: doc/BRIEF.md
# Up/Down Timer with Compare-Only Event Channels

This block pairs a 16-bit timer that counts up or down with four compare-only event channels. Each channel holds a compare value and a two-bit action code. A channel fires only when a counting step moves the timer onto its compare value. A value that lands on the timer through a register load does not fire it, and neither does a return to zero forced by a reset. When a channel fires, it pulses its event output and carries out its action. The action can set a sticky software flag, pulse a request to start an A/D conversion, or clear the timer to zero on the following clock.

Software reaches the timer value, the compare values, the action codes and the flags through a plain single-cycle register port. Writes take effect at the clock edge. Reads are combinational from the addressed register. Two plain control pins drive the timer: a count enable and a direction. The port carries register accesses and no stream, so it has no valid/ready handshake. Every write is taken in the cycle it is presented.

Top module: `cmp_event_timer`

## Requirements
- R1: After the asynchronous active-low reset, the timer, all compare values, all action codes and all flags read 0, and `evt_pulse`, `adc_start` and `swflag` are low.
- R2: While `cnt_en` is 1, the timer moves by one on each clock: up when `cnt_down` is 0, down when it is 1, wrapping modulo 2^16 in both directions. While `cnt_en` is 0, the timer holds its value.
- R3: `evt_pulse[i]` goes high for exactly one cycle. That cycle is the one in which the timer first reads channel i's compare value after a counting step onto it, in either direction and including a wrap.
- R4: Loading the timer (write to address 0) does not fire any channel, even when the loaded value equals a compare value. A load in the same cycle as `cnt_en` replaces that count step. Writing a compare value (address 1+i) does not fire the channel either, even when the value equals the current timer value.
- R5: Action code 01 sets sticky flag i when channel i fires. The flag appears on `swflag[i]` and in bit i of address 6. Writing 1 to bit i of address 6 clears the flag. If a set and a clear fall in the same cycle, the set wins.
- R6: Action code 10 drives `adc_start` high for one cycle, in the same cycle as the channel's `evt_pulse`.
- R7: Action code 11 clears the timer to 0 on the next clock. That clear overrides both a count step and a timer write presented in the same cycle, and the write is discarded. The clear fires no channel, including a channel whose compare value is 0.
- R8: Reads return the timer at address 0 and compare value i at address 1+i. Address 5 returns the action codes, with channel i's code in bits [2i+1:2i]. Address 6 returns the flags in bits [3:0]. Any other address reads 0.
- R9: Action code 00 produces `evt_pulse` only. It sets no flag, raises no `adc_start` and does not clear the timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_en | input | 1 | Count enable, one step per clock |
| cnt_down | input | 1 | Count direction: 0 up, 1 down |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data of the addressed register |
| evt_pulse | output | 4 | Per-channel match pulse |
| swflag | output | 4 | Sticky software flags |
| adc_start | output | 1 | A/D conversion start pulse |

## Verification
Two functions can collide in one cycle. The first collision is a channel-driven timer clear pending while software writes the timer and the count enable stays high. The bench provokes it by holding a timer write and `cnt_en` through the cycle that follows a reset-action match. It judges the result by reading 0 from the timer, not the written value and not the incremented value, and by seeing no event from a channel whose compare value is 0. The second collision is a flag set and a write-1 clear of the same flag landing on one edge. The bench expects the flag to stay set.

// File: rtl/cet_pkg.sv
package cet_pkg;
  typedef enum logic [1:0] {
    ACT_NONE = 2'b00,
    ACT_FLAG = 2'b01,
    ACT_ADC  = 2'b10,
    ACT_RST  = 2'b11
  } act_e;
endpackage

// File: rtl/cet_timer.sv
module cet_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          ld,
  input  logic [TW-1:0] ld_val,
  input  logic          cnt_en,
  input  logic          cnt_down,
  output logic [TW-1:0] tmr_q,
  output logic [TW-1:0] tmr_nxt,
  output logic          step
);
  // A counting step happens only when neither the clear nor a load claims the edge.
  always_comb begin
    step    = cnt_en && !clr && !ld;
    tmr_nxt = cnt_down ? (tmr_q - TW'(1)) : (tmr_q + TW'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    tmr_q <= '0;
    else if (clr)  tmr_q <= '0;
    else if (ld)   tmr_q <= ld_val;
    else if (step) tmr_q <= tmr_nxt;
  end
endmodule

// File: rtl/cet_channel.sv
module cet_channel
  import cet_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmp_wr,
  input  logic [TW-1:0] cmp_wdata,
  input  logic          act_wr,
  input  logic [1:0]    act_wdata,
  input  logic          flag_clr,
  input  logic          step,
  input  logic [TW-1:0] tmr_nxt,
  output logic [TW-1:0] cmp_q,
  output act_e          act_q,
  output logic          evt,
  output logic          flag,
  output logic          adc_req,
  output logic          rst_req
);
  logic hit;

  // Only a counting step onto the compare value counts as a hit.
  assign hit = step && (tmr_nxt == cmp_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q <= '0;
      act_q <= ACT_NONE;
    end else begin
      if (cmp_wr) cmp_q <= cmp_wdata;
      if (act_wr) act_q <= act_e'(act_wdata);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt     <= 1'b0;
      flag    <= 1'b0;
      adc_req <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      evt     <= hit;
      flag    <= (flag && !flag_clr) || (hit && act_q == ACT_FLAG);
      adc_req <= hit && act_q == ACT_ADC;
      rst_req <= hit && act_q == ACT_RST;
    end
  end
endmodule

// File: rtl/cet_regs.sv
module cet_regs #(
  parameter int TW  = 16,
  parameter int NCH = 4,
  parameter int AW  = 3
) (
  input  logic                    reg_wr,
  input  logic [AW-1:0]           reg_addr,
  input  logic [TW-1:0]           reg_wdata,
  input  logic [TW-1:0]           tmr_q,
  input  logic [NCH-1:0][TW-1:0]  cmp_all,
  input  logic [2*NCH-1:0]        act_all,
  input  logic [NCH-1:0]          flags,
  output logic                    tmr_ld,
  output logic [NCH-1:0]          cmp_wr,
  output logic                    act_wr,
  output logic [NCH-1:0]          flag_clr,
  output logic [TW-1:0]           reg_rdata
);
  localparam logic [AW-1:0] A_TMR = '0;
  localparam logic [AW-1:0] A_ACT = AW'(NCH + 1);
  localparam logic [AW-1:0] A_FLG = AW'(NCH + 2);

  always_comb begin
    tmr_ld = reg_wr && (reg_addr == A_TMR);
    act_wr = reg_wr && (reg_addr == A_ACT);
    for (int i = 0; i < NCH; i++) begin
      cmp_wr[i]   = reg_wr && (reg_addr == AW'(i + 1));
      flag_clr[i] = reg_wr && (reg_addr == A_FLG) && reg_wdata[i];
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == A_TMR) reg_rdata = tmr_q;
    for (int i = 0; i < NCH; i++) begin
      if (reg_addr == AW'(i + 1)) reg_rdata = cmp_all[i];
    end
    if (reg_addr == A_ACT) reg_rdata = TW'(act_all);
    if (reg_addr == A_FLG) reg_rdata = TW'(flags);
  end
endmodule

// File: rtl/cmp_event_timer.sv
module cmp_event_timer
  import cet_pkg::*;
#(
  parameter int TW  = 16,
  parameter int NCH = 4,
  parameter int AW  = $clog2(NCH + 3)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cnt_en,
  input  logic           cnt_down,
  input  logic           reg_wr,
  input  logic [AW-1:0]  reg_addr,
  input  logic [TW-1:0]  reg_wdata,
  output logic [TW-1:0]  reg_rdata,
  output logic [NCH-1:0] evt_pulse,
  output logic [NCH-1:0] swflag,
  output logic           adc_start
);
  logic [TW-1:0]          tmr_q;
  logic [TW-1:0]          tmr_nxt;
  logic                   step;
  logic                   rst_pend;
  logic                   tmr_ld;
  logic                   act_wr;
  logic [NCH-1:0]         cmp_wr;
  logic [NCH-1:0]         flag_clr;
  logic [NCH-1:0][TW-1:0] cmp_all;
  logic [2*NCH-1:0]       act_all;
  logic [NCH-1:0]         adc_req;
  logic [NCH-1:0]         rst_req;

  assign rst_pend  = |rst_req;
  assign adc_start = |adc_req;

  cet_timer #(.TW(TW)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (rst_pend),
    .ld       (tmr_ld),
    .ld_val   (reg_wdata),
    .cnt_en   (cnt_en),
    .cnt_down (cnt_down),
    .tmr_q    (tmr_q),
    .tmr_nxt  (tmr_nxt),
    .step     (step)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    act_e act_i;
    cet_channel #(.TW(TW)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmp_wr    (cmp_wr[i]),
      .cmp_wdata (reg_wdata),
      .act_wr    (act_wr),
      .act_wdata (reg_wdata[2*i +: 2]),
      .flag_clr  (flag_clr[i]),
      .step      (step),
      .tmr_nxt   (tmr_nxt),
      .cmp_q     (cmp_all[i]),
      .act_q     (act_i),
      .evt       (evt_pulse[i]),
      .flag      (swflag[i]),
      .adc_req   (adc_req[i]),
      .rst_req   (rst_req[i])
    );
    assign act_all[2*i +: 2] = act_i;
  end

  cet_regs #(.TW(TW), .NCH(NCH), .AW(AW)) u_regs (
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .tmr_q     (tmr_q),
    .cmp_all   (cmp_all),
    .act_all   (act_all),
    .flags     (swflag),
    .tmr_ld    (tmr_ld),
    .cmp_wr    (cmp_wr),
    .act_wr    (act_wr),
    .flag_clr  (flag_clr),
    .reg_rdata (reg_rdata)
  );
endmodule

// File: rtl/cet_chk.sv
module cet_chk #(
  parameter int TW  = 16,
  parameter int NCH = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cnt_en,
  input logic [TW-1:0]          tmr_q,
  input logic                   rst_pend,
  input logic [NCH-1:0]         evt_pulse,
  input logic                   adc_start,
  input logic [NCH-1:0][TW-1:0] cmp_all
);
  // R3
  evt_needs_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_pulse) |-> ($past(cnt_en) && !$past(rst_pend)));

  // R7
  rst_clears_tmr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pend |=> (tmr_q == '0));

  // R7
  rst_no_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pend |=> (evt_pulse == '0));

  // R6
  adc_with_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |-> (|evt_pulse));

  for (genvar i = 0; i < NCH; i++) begin : g_c
    // R3
    evt_on_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_pulse[i] |-> (tmr_q == $past(cmp_all[i])));

    // R3
    evt_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_pulse[i] |=> !evt_pulse[i]);
  end
endmodule

bind cmp_event_timer cet_chk #(.TW(TW), .NCH(NCH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cnt_en    (cnt_en),
  .tmr_q     (tmr_q),
  .rst_pend  (rst_pend),
  .evt_pulse (evt_pulse),
  .adc_start (adc_start),
  .cmp_all   (cmp_all)
);

// File: tb/cmp_event_timer_tb.sv
module cmp_event_timer_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_en = 1'b0;
  logic        cnt_down = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [15:0] reg_wdata = 16'd0;
  logic [15:0] reg_rdata;
  logic [3:0]  evt_pulse;
  logic [3:0]  swflag;
  logic        adc_start;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmp_event_timer u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_en    (cnt_en),
    .cnt_down  (cnt_down),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .evt_pulse (evt_pulse),
    .swflag    (swflag),
    .adc_start (adc_start)
  );

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 3'd0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
    reg_addr = 3'd0;
  endtask

  task automatic step(input logic dn);
    cnt_down = dn; cnt_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cnt_en = 1'b0;
  endtask

  task automatic idle();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cfg(input logic [15:0] c0, input logic [15:0] c1, input logic [15:0] c2,
                     input logic [15:0] c3, input logic [7:0] acts);
    wr(3'd1, c0); wr(3'd2, c1); wr(3'd3, c2); wr(3'd4, c3);
    wr(3'd5, {8'h00, acts});
    wr(3'd6, 16'h000F);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    rd(3'd0, d); chk("R1", "timer after reset", d, 16'h0);
    rd(3'd2, d); chk("R1", "cmp1 after reset", d, 16'h0);
    rd(3'd5, d); chk("R1", "actions after reset", d, 16'h0);
    rd(3'd6, d); chk("R1", "flags after reset", d, 16'h0);
    chk("R1", "evt after reset", {12'h0, evt_pulse}, 16'h0);
    chk("R1", "adc after reset", {15'h0, adc_start}, 16'h0);
  endtask

  task automatic t_count_up_flag();
    logic [15:0] d;
    cfg(16'd5, 16'hAAAA, 16'hAAAA, 16'hAAAA, 8'b00_00_00_01);
    wr(3'd0, 16'd3);
    step(1'b0);
    rd(3'd0, d); chk("R2", "count up to 4", d, 16'd4);
    chk("R3", "no evt at 4", {12'h0, evt_pulse}, 16'h0);
    step(1'b0);
    chk("R3", "evt at 5 up", {12'h0, evt_pulse}, 16'h1);
    chk("R5", "flag set", {12'h0, swflag}, 16'h1);
    step(1'b0);
    chk("R3", "evt one cycle", {12'h0, evt_pulse}, 16'h0);
    rd(3'd6, d); chk("R5", "flag sticky", d, 16'h1);
    wr(3'd6, 16'h0001);
    chk("R5", "flag cleared", {12'h0, swflag}, 16'h0);
    // set and clear on the same edge: set wins
    wr(3'd0, 16'd4);
    @(negedge clk);
    cnt_down = 1'b0; cnt_en = 1'b1;
    reg_wr = 1'b1; reg_addr = 3'd6; reg_wdata = 16'h0001;
    @(posedge clk);
    @(negedge clk);
    cnt_en = 1'b0; reg_wr = 1'b0; reg_addr = 3'd0;
    chk("R5", "set wins over clear", {12'h0, swflag}, 16'h1);
  endtask

  task automatic t_down_adc();
    cfg(16'hAAAA, 16'd9, 16'hAAAA, 16'hAAAA, 8'b00_00_10_00);
    wr(3'd0, 16'd11);
    step(1'b1);
    chk("R6", "no adc at 10", {15'h0, adc_start}, 16'h0);
    step(1'b1);
    chk("R3", "evt at 9 down", {12'h0, evt_pulse}, 16'h2);
    chk("R6", "adc pulse", {15'h0, adc_start}, 16'h1);
    chk("R6", "adc sets no flag", {12'h0, swflag}, 16'h0);
    idle();
    chk("R6", "adc one cycle", {15'h0, adc_start}, 16'h0);
  endtask

  task automatic t_wrap_none();
    logic [15:0] d;
    cfg(16'hFFFF, 16'h0000, 16'hAAAA, 16'hAAAA, 8'b00_00_00_00);
    wr(3'd0, 16'h0000);
    chk("R4", "load onto cmp1 no evt", {12'h0, evt_pulse}, 16'h0);
    step(1'b1);
    rd(3'd0, d); chk("R2", "wrap down", d, 16'hFFFF);
    chk("R3", "evt on wrap down", {12'h0, evt_pulse}, 16'h1);
    chk("R9", "none: no flag", {12'h0, swflag}, 16'h0);
    chk("R9", "none: no adc", {15'h0, adc_start}, 16'h0);
    idle();
    rd(3'd0, d); chk("R9", "none: no timer clear", d, 16'hFFFF);
    wr(3'd0, 16'hFFFF);
    chk("R4", "load onto cmp0 no evt", {12'h0, evt_pulse}, 16'h0);
    step(1'b0);
    rd(3'd0, d); chk("R2", "wrap up", d, 16'h0000);
    chk("R3", "evt on wrap up", {12'h0, evt_pulse}, 16'h2);
  endtask

  task automatic t_cmp_write_hold();
    logic [15:0] d;
    cfg(16'hAAAA, 16'hAAAA, 16'hAAAA, 16'hAAAA, 8'b00_00_00_01);
    wr(3'd0, 16'h0040);
    wr(3'd1, 16'h0040);
    chk("R4", "cmp write equal no evt", {12'h0, evt_pulse}, 16'h0);
    idle();
    chk("R4", "cmp write equal no flag", {12'h0, swflag}, 16'h0);
    idle(); idle();
    rd(3'd0, d); chk("R2", "hold without enable", d, 16'h0040);
    // a load in the same cycle as cnt_en replaces the step
    @(negedge clk);
    cnt_en = 1'b1; cnt_down = 1'b0;
    reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 16'h0041;
    @(posedge clk);
    @(negedge clk);
    cnt_en = 1'b0; reg_wr = 1'b0; reg_addr = 3'd0;
    rd(3'd0, d); chk("R4", "load wins over step", d, 16'h0041);
    step(1'b1);
    chk("R3", "evt after later step", {12'h0, evt_pulse}, 16'h1);
    chk("R5", "flag after later step", {12'h0, swflag}, 16'h1);
  endtask

  task automatic t_reset_action(input logic with_write);
    logic [15:0] d;
    cfg(16'hAAAA, 16'hAAAA, 16'h0000, 16'd20, 8'b11_01_00_00);
    wr(3'd0, 16'd18);
    step(1'b0);
    @(negedge clk);
    cnt_down = 1'b0; cnt_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R7", "evt3 at 20", {12'h0, evt_pulse}, 16'h8);
    if (with_write) begin
      reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 16'h0100;
    end
    @(posedge clk);
    @(negedge clk);
    cnt_en = 1'b0; reg_wr = 1'b0; reg_addr = 3'd0;
    rd(3'd0, d);
    chk("R7", with_write ? "clear beats write" : "clear beats count", d, 16'h0);
    chk("R7", "no evt from clear", {12'h0, evt_pulse}, 16'h0);
    chk("R7", "no flag from clear on cmp 0", {12'h0, swflag}, 16'h0);
    step(1'b0);
    rd(3'd0, d); chk("R7", "counts on after clear", d, 16'd1);
  endtask

  task automatic t_regmap();
    logic [15:0] d;
    cfg(16'h1111, 16'h2222, 16'h3333, 16'h4444, 8'b00_10_01_00);
    rd(3'd1, d); chk("R8", "read cmp0", d, 16'h1111);
    rd(3'd2, d); chk("R8", "read cmp1", d, 16'h2222);
    rd(3'd3, d); chk("R8", "read cmp2", d, 16'h3333);
    rd(3'd4, d); chk("R8", "read cmp3", d, 16'h4444);
    rd(3'd5, d); chk("R8", "read actions", d, 16'h0024);
    rd(3'd7, d); chk("R8", "read unused", d, 16'h0000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_count_up_flag();
    t_down_adc();
    t_wrap_none();
    t_cmp_write_hold();
    t_reset_action(1'b0);
    t_reset_action(1'b1);
    t_regmap();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule